// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block produces one system reset signal from three sources: a supply-good flag already turned into a digital level by an external comparator, an active-low push-button style manual reset, and a watchdog line that software has to toggle regularly. All three inputs may be asynchronous to the block clock. Each one passes through a two-flop synchroniser. The manual reset and watchdog lines then go through a pulse-width qualifier counted in clock cycles, so glitches narrower than a parameterised minimum are discarded.

Reset is in force while the supply flag is false or the manual reset is held low. Once both conditions clear, reset is kept for a release delay before it lets go. If the watchdog is enabled and neither edge arrives on the watchdog line within the selected timeout, reset is forced. It is held for one full release delay, and the watchdog timer then restarts from zero. After every accepted watchdog edge there is a short blanking window in which further edges are ignored. A free-running prescaler sets the time base. Both the release delay and the timeout are counted in its ticks. Each is chosen from a small table by a 3-bit select code. A combinational flag reports select combinations that are not allowed. The polarity of the reset output is fixed at build time.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While the synchronised supply flag is low, reset is in force. It appears at the output no more than 6 clock cycles after `supply_ok` falls and stays for as long as the flag stays low.
- R2: After the last hold condition clears, reset stays in force for the release delay and then releases within one tick period of that delay. The delay in ticks is UNIT_TICKS times 1, 8, 16, 32, 64, 128 and 512 for `rd_sel` codes 0 to 6. Code 7 uses 512.
- R3: A low level on `mr_n` that lasts at least MR_MIN_W cycles forces reset within MR_MIN_W+5 cycles of the falling edge. Reset is kept until the release delay has run out, counted from the qualified return of `mr_n` to high.
- R4: A pulse on `mr_n` or `wd_in` that is shorter than its minimum width (MR_MIN_W or WD_MIN_W cycles) has no effect on the reset output or on the watchdog timer.
- R5: A qualified rising edge and a qualified falling edge on `wd_in` each restart the watchdog timer. If no edge is accepted for the timeout, reset is forced. The timeout in ticks is UNIT_TICKS times 2, 16, 32, 64, 128 and 512 for `wd_sel` codes 1 to 6.
- R6: A watchdog timeout holds reset for one full release delay and then releases it. The timer then starts again from zero, so the next timeout comes one full timeout after the release.
- R7: For BLANK_TICKS ticks after an accepted watchdog edge, further edges on `wd_in` are ignored and do not restart the timer.
- R8: With `wd_sel` equal to 0 or 7 the watchdog is off, and a silent `wd_in` never causes a reset.
- R9: `cfg_illegal` is 1 when `rd_sel` is 7, when `wd_sel` is 7, or when the watchdog is enabled and the release delay is longer than the timeout. Otherwise it is 0.
- R10: With ACTIVE_HIGH = 0, `sys_rst` is low while reset is in force. With ACTIVE_HIGH = 1, it is high while reset is in force.
- R11: While reset is held by the supply or manual condition, the watchdog timer stays cleared. After release, the first timeout comes no earlier than one full timeout later.
- R12: While `rst_n` is low, reset is in force at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's own state |
| supply_ok | input | 1 | Asynchronous supply-good level, high when the supply is good |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| wd_in | input | 1 | Asynchronous watchdog service line; both edges count |
| rd_sel | input | 3 | Release delay select code |
| wd_sel | input | 3 | Watchdog timeout select code; 0 and 7 disable it |
| sys_rst | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| cfg_illegal | output | 1 | High for a select combination that is not allowed |

## Verification
A wrong delay counter or a prescaler that loses ticks shows up at the release edge. The reset lets go too early or too late, and the error is visible within one release delay of the cause. If the watchdog timer is not cleared or is cleared at the wrong moment, the next forced reset moves by whole tick periods. This is seen one timeout after the last accepted edge. Faults in the qualifier or the blanking window change which edges count. The bench places glitches and edges inside the blanking window so that such a fault moves the timeout well past a checked cycle.

// File: rtl/sup_pkg.sv
// Shared constants and select-code decoding for the supervisory reset controller.
// Assumes 3-bit select codes; the tables return multiples of a base time unit.
package sup_pkg;
    localparam int SEL_W = 3;
    typedef logic [SEL_W-1:0] sup_sel_t;

    // Release delay in base units; code 7 is not allowed and maps to the longest value.
    function automatic int unsigned rd_units(input sup_sel_t code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 8;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            default: return 512;
        endcase
    endfunction

    // Watchdog timeout in base units; zero means the watchdog is off.
    function automatic int unsigned wd_units(input sup_sel_t code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            3'd6:    return 512;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/sup_sync_filter.sv
// Two-flop synchroniser followed by a width qualifier: the filtered level only
// follows the synchronised input after that input has differed from it for MIN_W
// consecutive cycles. Assumes MIN_W >= 1; INIT is the level held during reset.
module sup_sync_filter #(
    parameter int MIN_W = 1,
    parameter bit INIT  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic [1:0] sync_q;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{INIT}};
        else        sync_q <= {sync_q[0], async_in};
    end

    generate
        if (MIN_W <= 1) begin : g_direct
            // Register the synchronised level without qualification.
            always_ff @(posedge clk) begin
                if (!rst_n) level <= INIT;
                else        level <= sync_q[1];
            end
        end else begin : g_qual
            localparam int QW = $clog2(MIN_W);
            logic [QW-1:0] run;

            // Count consecutive differing samples and accept the new level at MIN_W.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run   <= '0;
                    level <= INIT;
                end else if (sync_q[1] == level) begin
                    run <= '0;
                end else if (run == QW'(MIN_W - 1)) begin
                    run   <= '0;
                    level <= sync_q[1];
                end else begin
                    run <= run + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sup_tick.sv
// Free-running prescaler: one-cycle tick every DIV clock cycles. Assumes DIV >= 2.
module sup_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = $clog2(DIV);
    logic [DW-1:0] cnt;

    // Divide the clock and emit a registered tick pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == DW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sup_wdog.sv
// Watchdog timer: any change of the qualified service level restarts it, unless a
// blanking window from the previous accepted change is still open. Emits a one-cycle
// timeout when `limit` ticks pass without service. Assumes limit >= 1 when enabled;
// `clear` holds everything at zero.
module sup_wdog #(
    parameter int CNT_W       = 11,
    parameter int BLANK_TICKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wd_lvl,
    input  logic             clear,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             timeout
);
    localparam int BW = $clog2(BLANK_TICKS + 1);

    logic             lvl_q;
    logic [BW-1:0]    blank;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept = (wd_lvl ^ lvl_q) && (blank == '0) && !clear;

    // Remember the previous level so that both directions of change are seen.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= wd_lvl;
    end

    // Open the blanking window on an accepted edge and close it tick by tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)            blank <= '0;
        else if (accept)                blank <= BW'(BLANK_TICKS);
        else if (tick && blank != '0)   blank <= blank - 1'b1;
    end

    // Count ticks since the last service and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (clear || !enable || accept) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == limit - CNT_W'(1)) begin
                    cnt     <= '0;
                    timeout <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sup_reset_ctrl.sv
// Supervisory reset controller. Combines supply-good, manual reset and watchdog into
// one system reset, holds it for a selectable release delay, and flags select
// combinations that are not allowed. Assumes all three sources are asynchronous and
// the select codes are quasi-static.
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter int UNIT_TICKS  = 2,
    parameter int BLANK_TICKS = 8,
    parameter int SUP_MIN_W   = 1,
    parameter int MR_MIN_W    = 5,
    parameter int WD_MIN_W    = 3,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic             mr_n,
    input  logic             wd_in,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [SEL_W-1:0] wd_sel,
    output logic             sys_rst,
    output logic             cfg_illegal
);
    localparam int MAX_TICKS = 512 * UNIT_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic             tick;
    logic             sup_lvl;
    logic             mr_lvl;
    logic             wd_lvl;
    logic             wd_timeout;
    logic             rst_act;
    logic             hold_req;
    logic             wd_en;
    logic [CNT_W-1:0] rd_ticks;
    logic [CNT_W-1:0] wd_ticks;
    logic [CNT_W-1:0] dly_cnt;

    // Decode the select codes into tick counts.
    assign rd_ticks    = CNT_W'(rd_units(rd_sel) * UNIT_TICKS);
    assign wd_ticks    = CNT_W'(wd_units(wd_sel) * UNIT_TICKS);
    assign wd_en       = (wd_ticks != '0);
    assign cfg_illegal = (rd_sel == 3'd7) || (wd_sel == 3'd7) ||
                         (wd_en && (rd_ticks > wd_ticks));
    assign hold_req    = !sup_lvl || !mr_lvl;

    sup_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sup_sync_filter #(.MIN_W(SUP_MIN_W), .INIT(1'b0)) u_sup_in (
        .clk(clk), .rst_n(rst_n), .async_in(supply_ok), .level(sup_lvl)
    );

    sup_sync_filter #(.MIN_W(MR_MIN_W), .INIT(1'b1)) u_mr_in (
        .clk(clk), .rst_n(rst_n), .async_in(mr_n), .level(mr_lvl)
    );

    sup_sync_filter #(.MIN_W(WD_MIN_W), .INIT(1'b0)) u_wd_in (
        .clk(clk), .rst_n(rst_n), .async_in(wd_in), .level(wd_lvl)
    );

    sup_wdog #(.CNT_W(CNT_W), .BLANK_TICKS(BLANK_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wd_lvl(wd_lvl),
        .clear(rst_act), .enable(wd_en), .limit(wd_ticks), .timeout(wd_timeout)
    );

    // Hold reset on any cause, then release after the selected number of ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_act <= 1'b1;
            dly_cnt <= '0;
        end else if (hold_req || wd_timeout) begin
            rst_act <= 1'b1;
            dly_cnt <= '0;
        end else if (rst_act && tick) begin
            if (dly_cnt == rd_ticks - CNT_W'(1)) begin
                rst_act <= 1'b0;
                dly_cnt <= '0;
            end else begin
                dly_cnt <= dly_cnt + 1'b1;
            end
        end
    end

    generate
        if (ACTIVE_HIGH) begin : g_out_high
            assign sys_rst = rst_act;
        end else begin : g_out_low
            assign sys_rst = !rst_act;
        end
    endgenerate
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
// Property checker for the supervisory reset controller, attached by bind.
// Observes internal levels of the controller; drives nothing.
module sup_reset_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sup_lvl,
    input logic mr_lvl,
    input logic rst_act,
    input logic wd_timeout,
    input logic tick
);
    p_hold_forces_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_lvl || !mr_lvl) |=> rst_act);

    p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> $past(tick));

    p_release_needs_clear_inputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_act) |-> $past(sup_lvl && mr_lvl));

    p_timeout_forces_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |=> rst_act);

    p_timer_quiet_in_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wd_timeout |-> !$past(rst_act));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sup_lvl(sup_lvl), .mr_lvl(mr_lvl),
    .rst_act(rst_act), .wd_timeout(wd_timeout), .tick(tick)
);

// File: tb/sup_reset_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected reset levels at future cycles, the
// monitor compares both polarity variants when each cycle arrives.
module sup_reset_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n, supply_ok, mr_n, wd_in;
    logic [2:0] rd_sel, wd_sel;
    logic       rst_lo, rst_hi, ill_lo, ill_hi;

    int unsigned cyc = 0;
    int          checks = 0;
    int          errors = 0;

    typedef struct {
        int unsigned at;
        bit          asrt;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sup_reset_ctrl #(.ACTIVE_HIGH(1'b0)) u_sup_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wd_in(wd_in),
        .rd_sel(rd_sel), .wd_sel(wd_sel), .sys_rst(rst_lo), .cfg_illegal(ill_lo)
    );

    sup_reset_ctrl #(.ACTIVE_HIGH(1'b1)) u_sup_reset_ctrl_hi (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wd_in(wd_in),
        .rd_sel(rd_sel), .wd_sel(wd_sel), .sys_rst(rst_hi), .cfg_illegal(ill_hi)
    );

    task automatic expect_at(input int unsigned off, input bit asrt, input string tag);
        exp_t it;
        int   idx;
        it.at   = cyc + off;
        it.asrt = asrt;
        it.tag  = tag;
        idx = sbq.size();
        while (idx > 0 && sbq[idx-1].at > it.at) idx--;
        sbq.insert(idx, it);
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
    endtask

    task automatic wait_level(input bit asrt, output int unsigned t);
        int n = 0;
        while (((rst_lo == 1'b0) != asrt) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Monitor: compare both outputs against each expected item when its cycle comes.
    always @(negedge clk) begin : mon
        exp_t it;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            it = sbq.pop_front();
            checks++;
            if (rst_lo !== !it.asrt) begin
                errors++;
                $display("FAIL %s: low-active output %0b expected %0b at cycle %0d",
                         it.tag, rst_lo, !it.asrt, cyc);
            end
            checks++;
            if (rst_hi !== it.asrt) begin
                errors++;
                $display("FAIL R10 (%s): high-active output %0b expected %0b at cycle %0d",
                         it.tag, rst_hi, it.asrt, cyc);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL run: hung at cycle %0d expected end before %0d", cyc, 150000);
        report();
        $finish;
    end

    initial begin
        int unsigned t;
        rst_n = 1'b0; supply_ok = 1'b0; mr_n = 1'b1; wd_in = 1'b0;
        rd_sel = 3'd1; wd_sel = 3'd0;
        step(3);
        check_bit(rst_lo, 1'b0, "R12");
        check_bit(rst_hi, 1'b1, "R12");
        check_bit(ill_lo, 1'b0, "R9");
        rst_n = 1'b1;
        expect_at(8, 1'b1, "R1");
        step(10);
        drain();

        // R2: release delay with code 1 (16 ticks)
        supply_ok = 1'b1;
        expect_at(62, 1'b1, "R2"); expect_at(70, 1'b0, "R2");
        drain();

        // R1: supply drop holds reset
        supply_ok = 1'b0;
        expect_at(6, 1'b1, "R1"); expect_at(200, 1'b1, "R1");
        drain();
        supply_ok = 1'b1;
        expect_at(62, 1'b1, "R2"); expect_at(70, 1'b0, "R2");
        drain();

        // R2: code 0 (2 ticks) and code 2 (32 ticks)
        rd_sel = 3'd0;
        supply_ok = 1'b0; step(20); supply_ok = 1'b1;
        expect_at(6, 1'b1, "R2"); expect_at(14, 1'b0, "R2");
        drain();
        rd_sel = 3'd2;
        supply_ok = 1'b0; step(20); supply_ok = 1'b1;
        expect_at(126, 1'b1, "R2"); expect_at(134, 1'b0, "R2");
        drain();
        rd_sel = 3'd1;

        // R3: manual reset asserts quickly, releases after delay from rising edge
        mr_n = 1'b0;
        expect_at(10, 1'b1, "R3"); expect_at(38, 1'b1, "R3");
        step(40);
        mr_n = 1'b1;
        expect_at(66, 1'b1, "R3"); expect_at(74, 1'b0, "R3");
        drain();

        // R4: short manual pulse ignored
        mr_n = 1'b0; step(2); mr_n = 1'b1;
        expect_at(10, 1'b0, "R4"); expect_at(30, 1'b0, "R4");
        drain();

        // R5: both edges service the watchdog (timeout 32 ticks)
        wd_sel = 3'd2;
        for (int k = 0; k < 8; k++) begin
            wd_in = ~wd_in;
            expect_at(40, 1'b0, "R5"); expect_at(79, 1'b0, "R5");
            step(80);
        end
        wd_in = ~wd_in;
        expect_at(128, 1'b0, "R5"); expect_at(137, 1'b1, "R5 R4");
        step(40);
        wd_in = ~wd_in; step(2); wd_in = ~wd_in;   // R4: glitch too short to count

        // R6: hold for release delay after timeout, then timer restarts
        wait_level(1'b1, t);
        expect_at(60, 1'b1, "R6"); expect_at(66, 1'b0, "R6");
        wait_level(1'b0, t);
        expect_at(124, 1'b0, "R6"); expect_at(131, 1'b1, "R6");
        drain();
        wait_level(1'b0, t);

        // R7: edge inside blanking window does not restart the timer
        wd_in = ~wd_in;
        expect_at(128, 1'b0, "R7"); expect_at(137, 1'b1, "R7");
        step(16);
        wd_in = ~wd_in;
        drain();
        wait_level(1'b0, t);

        // R11: timer kept clear while the supply holds reset
        supply_ok = 1'b0;
        expect_at(6, 1'b1, "R1"); expect_at(290, 1'b1, "R11");
        step(300);
        supply_ok = 1'b1;
        wait_level(1'b0, t);
        expect_at(60, 1'b0, "R11"); expect_at(124, 1'b0, "R11"); expect_at(131, 1'b1, "R11");
        drain();
        wait_level(1'b0, t);

        // R8: watchdog disabled
        wd_sel = 3'd0;
        expect_at(300, 1'b0, "R8"); expect_at(600, 1'b0, "R8");
        drain();

        // R9: configuration legality
        rd_sel = 3'd2; wd_sel = 3'd1; #1;
        check_bit(ill_lo, 1'b1, "R9"); check_bit(ill_hi, 1'b1, "R9");
        rd_sel = 3'd2; wd_sel = 3'd2; #1; check_bit(ill_lo, 1'b0, "R9");
        rd_sel = 3'd7; wd_sel = 3'd0; #1; check_bit(ill_lo, 1'b1, "R9");
        rd_sel = 3'd6; wd_sel = 3'd0; #1; check_bit(ill_lo, 1'b0, "R9");
        rd_sel = 3'd0; wd_sel = 3'd7; #1; check_bit(ill_lo, 1'b1, "R9");
        rd_sel = 3'd5; wd_sel = 3'd6; #1; check_bit(ill_lo, 1'b0, "R9");
        rd_sel = 3'd6; wd_sel = 3'd5; #1; check_bit(ill_lo, 1'b1, "R9");
        check_bit(rst_lo, 1'b1, "R8");

        report();
        $finish;
    end
endmodule